// File: doc/BRIEF.md
# Piezo Drive Waveform Generator

This block turns a single start strobe into one drive period for a piezoelectric actuator. It has two outputs, and their high and low times are counted in clock cycles only. Four count settings set the length of each interval. A direction input picks one of two motions. Each motion drives the two outputs in a different order.

Every period opens with a rest interval in which both outputs are low. In the "far" direction the first output then goes high, and after it the second output goes high, for the same number of cycles each. In the "near" direction the second output goes high first, then the first output. Each of those two intervals has its own count. A closing low interval follows, and its length is the one used by the far direction. The busy flag is high for the whole period. A one-cycle done pulse marks the last cycle of the period, so that an outer sequencer can chain periods.

Top module: `piezo_wave_gen`

## Requirements
- R1: After reset, and whenever no period is running, `drv_a`, `drv_b`, `busy` and `period_done` are all low.
- R2: A start accepted in an idle cycle begins a period on the next cycle. The period opens with `rest_cfg`+1 cycles in which both drive outputs are low.
- R3: With `dir_i`=0 (far motion), the rest is followed by `drv_a` high for L(`hold_cfg`) cycles and then by `drv_b` high for L(`hold_cfg`) cycles. L(v) is v−1, and is 1 when v is 0 or 1.
- R4: With `dir_i`=1 (near motion), the rest is followed by `drv_b` high for L(`lead_cfg`) cycles, then `drv_a` high for L(`trail_cfg`) cycles, then both low for L(`hold_cfg`) cycles.
- R5: `drv_a` and `drv_b` are never high in the same cycle.
- R6: `busy` is high in exactly the cycles of a running period. A start that arrives while `busy` is high is ignored.
- R7: The direction and all four count settings are captured with the accepted start. Changing them during a period does not alter that period.
- R8: `period_done` is high for exactly one cycle, the last cycle of each period. `busy` is low in the following cycle.
- R9: A count setting of 0 or 1 yields a one-cycle drive interval. It never yields an empty or wrapped interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| dir_i | input | 1 | Motion select: 0 far, 1 near |
| rest_cfg | input | CW | Rest count; rest lasts rest_cfg+1 cycles |
| hold_cfg | input | CW | Count for the far-motion intervals and the near-motion closing gap |
| lead_cfg | input | CW | Count for the first near-motion drive interval |
| trail_cfg | input | CW | Count for the second near-motion drive interval |
| drv_a | output | 1 | First drive output |
| drv_b | output | 1 | Second drive output |
| period_done | output | 1 | One-cycle pulse in the last cycle of a period |
| busy | output | 1 | High while a period runs |

## Verification
The bench compares every cycle of each period with a cycle-exact expectation, so an off-by-one in the +1 rest or the −1 drive counts shows up as an interval that is one cycle too long or too short. Settings of 0 and 1 are driven on purpose: a design without the clamp would wrap its counter into an interval of hundreds of cycles, or would skip the interval entirely. The settings and the direction are changed in the middle of a period, and a design that does not capture them at start would bend the pattern it is already running. A start pulse during a running period would restart or stretch the period in a design that accepts it while busy.

// File: rtl/piezo_wave_gen.sv
module piezo_wave_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic [CW-1:0] rest_cfg,
  input  logic [CW-1:0] hold_cfg,
  input  logic [CW-1:0] lead_cfg,
  input  logic [CW-1:0] trail_cfg,
  output logic          drv_a,
  output logic          drv_b,
  output logic          period_done,
  output logic          busy
);

  typedef enum logic [2:0] {S_IDLE, S_REST, S_P1, S_P2, S_P3} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          near_q;
  logic [CW-1:0] hold_q, lead_q, trail_q;

  function automatic logic [CW-1:0] span_m1(input logic [CW-1:0] v);
    return (v <= CW'(1)) ? '0 : v - CW'(2);
  endfunction

  wire zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      near_q  <= 1'b0;
      hold_q  <= '0;
      lead_q  <= '0;
      trail_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st      <= S_REST;
          cnt     <= rest_cfg;
          near_q  <= dir_i;
          hold_q  <= span_m1(hold_cfg);
          lead_q  <= span_m1(lead_cfg);
          trail_q <= span_m1(trail_cfg);
        end
        S_REST: if (zero) begin
          st  <= S_P1;
          cnt <= near_q ? lead_q : hold_q;
        end else cnt <= cnt - 1'b1;
        S_P1: if (zero) begin
          st  <= S_P2;
          cnt <= near_q ? trail_q : hold_q;
        end else cnt <= cnt - 1'b1;
        S_P2: if (zero) begin
          st  <= near_q ? S_P3 : S_IDLE;
          cnt <= hold_q;
        end else cnt <= cnt - 1'b1;
        S_P3: if (zero) st <= S_IDLE;
              else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign drv_a       = (st == S_P1 && !near_q) || (st == S_P2 && near_q);
  assign drv_b       = (st == S_P2 && !near_q) || (st == S_P1 && near_q);
  assign busy        = (st != S_IDLE);
  assign period_done = zero && ((st == S_P2 && !near_q) || st == S_P3);

endmodule

module piezo_wave_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic drv_a,
  input logic drv_b,
  input logic period_done,
  input logic busy
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(drv_a && drv_b)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!drv_a && !drv_b && !period_done)); // R1
  AST_REST_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (!drv_a && !drv_b)); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start_i) |=> busy); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !period_done) |=> busy); // R6
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n) period_done |=> !busy); // R8
  AST_DONE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) period_done |-> busy); // R8
endmodule

bind piezo_wave_gen piezo_wave_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .drv_a(drv_a), .drv_b(drv_b),
  .period_done(period_done), .busy(busy)
);

// File: tb/piezo_wave_gen_test.sv
module piezo_wave_gen_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, dir_i = 1'b0;
  logic [CW-1:0] rest_cfg = '0, hold_cfg = '0, lead_cfg = '0, trail_cfg = '0;
  logic drv_a, drv_b, period_done, busy;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  piezo_wave_gen #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .rest_cfg(rest_cfg), .hold_cfg(hold_cfg), .lead_cfg(lead_cfg), .trail_cfg(trail_cfg),
    .drv_a(drv_a), .drv_b(drv_b), .period_done(period_done), .busy(busy)
  );

  function automatic int span(input int v);
    return (v <= 1) ? 1 : v - 1;
  endfunction

  function automatic int total_len(input bit d, input int r, input int h, input int l, input int t);
    if (!d) return r + 1 + 2 * span(h);
    return r + 1 + span(l) + span(t) + span(h);
  endfunction

  // returns {busy, a, b, done}
  function automatic logic [3:0] expect_at(input bit d, input int r, input int h, input int l,
                                           input int t, input int i);
    int tot = total_len(d, r, h, l, t);
    int e1, e2;
    logic a = 0, b = 0;
    if (i >= tot) return 4'b0000;
    e1 = r + 1 + (d ? span(l) : span(h));
    e2 = e1 + (d ? span(t) : span(h));
    if (i >= r + 1 && i < e1) begin a = !d; b = d; end
    else if (i >= e1 && i < e2) begin a = d; b = !d; end
    return {1'b1, a, b, (i == tot - 1)};
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {busy,a,b,done} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic run_period(input bit d, input int r, input int h, input int l, input int t,
                            input bit mutate, input bit poke, input string tag);
    int tot = total_len(d, r, h, l, t);
    string lab;
    dir_i = d; rest_cfg = CW'(r); hold_cfg = CW'(h); lead_cfg = CW'(l); trail_cfg = CW'(t);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i <= tot + 1; i++) begin
      logic [3:0] e = expect_at(d, r, h, l, t, i);
      if (drv_a && drv_b) lab = "R5";
      else if (busy !== e[3]) lab = (i >= tot) ? "R8" : "R6";
      else if (period_done !== e[0]) lab = "R8";
      else if (i <= r) lab = "R2";
      else lab = tag;
      check(lab, {busy, drv_a, drv_b, period_done}, e);
      if (mutate && i == 1) begin
        dir_i = ~d; rest_cfg = CW'(r + 3); hold_cfg = CW'(h + 2);
        lead_cfg = CW'(l + 5); trail_cfg = CW'(t + 1);
      end
      if (poke && i == 2) start_i = 1'b1;
      if (poke && i == 3) start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", {busy, drv_a, drv_b, period_done}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {busy, drv_a, drv_b, period_done}, 4'b0000);

    run_period(0, 2, 5, 0, 0, 0, 0, "R3");
    run_period(1, 1, 4, 6, 3, 0, 0, "R4");
    run_period(0, 0, 0, 0, 0, 0, 0, "R9");
    run_period(1, 0, 1, 0, 1, 0, 0, "R9");
    run_period(1, 0, 2, 2, 2, 0, 0, "R4");
    run_period(0, 255, 255, 0, 0, 0, 0, "R3");
    run_period(1, 255, 255, 255, 255, 0, 0, "R4");
    run_period(0, 4, 6, 3, 3, 1, 0, "R7");
    run_period(1, 4, 3, 7, 5, 1, 0, "R7");
    run_period(0, 4, 3, 0, 0, 0, 1, "R6");
    run_period(1, 5, 2, 3, 4, 0, 1, "R6");

    for (int k = 0; k < 40; k++) begin
      bit d = 1'($urandom);
      int r = int'($urandom % 20);
      int h = int'($urandom % 20);
      int l = int'($urandom % 20);
      int t = int'($urandom % 20);
      run_period(d, r, h, l, t, 0, 0, d ? "R4" : "R3");
      repeat (int'($urandom % 3)) begin
        check("R1 gap", {busy, drv_a, drv_b, period_done}, 4'b0000);
        @(negedge clk);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule